// File: doc/BRIEF.md
# Masked Legacy Interrupt Controller

This block collects up to eight device interrupt sources into an 8-bit pending register and presents a single level-sensitive request, `irq_out`, to an upstream chipset input. Devices act on the pending register through two bit-vector strobes. One sets bits and the other clears them. Software reaches the controller through a byte-addressed register port. From that port it reads the pending byte, writes an active-high disable mask, and acknowledges one source at a time by writing that source's index. A second controller position answers at its own offsets only as a stub. Its status reads as zero, its acknowledge writes do nothing, and its mask byte is kept but drives nothing.

The output is a pure level. It is high exactly when some pending bit is also enabled. It follows every change of mask, pending or acknowledge on the same clock edge that applies the change. The block has no priority logic, no vectors, no edge detection and no cascade handling.

Every access gets a registered response one cycle later: a `acc_ready` pulse with read data and an `acc_error` flag. Size codes on `acc_size` are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit.

Top module: `legacy_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, pending is 0, all sources are masked (the mask reads back 0xFF), and `irq_out`, `acc_ready`, `acc_error` and `acc_rdata` are all 0.
- R2: A byte write at offset 0x21 stores the written byte as the primary mask. A 1 in bit i disables source i and a 0 enables it. A byte read at 0x21 returns the byte last written.
- R3: An access presented with `acc_valid` high in cycle n gives `acc_ready` high in cycle n+1 only, with its read data on `acc_rdata` in that cycle. Read data reflects the state before any update made at the same edge. Non-read and error accesses return 0.
- R4: A byte write at offset 0x20 is an acknowledge. It clears pending bit k, where k is the value of write-data bits [3:0]. When k is 8 or more, nothing changes.
- R5: On each edge, pending becomes ((pending OR set vector) AND NOT clear vector), with the acknowledged bit also removed. A clear or an acknowledge therefore wins over a set of the same bit in the same cycle.
- R6: `irq_out` is high exactly when (pending AND NOT mask) is nonzero. It reflects a mask write, set, clear or acknowledge in the cycle after the edge that applied it.
- R7: A byte read at offset 0xA0 returns 0. A byte write there changes no state.
- R8: A byte write at 0xA1 is stored and read back by a byte read at 0xA1. It never affects `irq_out` or pending.
- R9: A 64-bit read (size 3) at offset 0x20 returns the pending byte zero-extended to 64 bits, without error.
- R10: Any 16-bit or 32-bit access, any 64-bit write, and any 64-bit read at an offset other than 0x20 responds with `acc_error` high together with `acc_ready` and read data 0. Such an access changes neither mask, pending nor the secondary mask.
- R11: A byte access at any other offset reads 0, ignores write data and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | Register access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| acc_offset | input | 8 | Port offset of the access |
| acc_wdata | input | 8 | Write data byte |
| acc_ready | output | 1 | Response pulse, one cycle after the access |
| acc_error | output | 1 | Access error, valid with acc_ready |
| acc_rdata | output | 64 | Read data, valid with acc_ready |
| dev_set_vec | input | 8 | Device strobe: bits to set in pending |
| dev_clr_vec | input | 8 | Device strobe: bits to clear in pending |
| irq_out | output | 1 | Level interrupt request upstream |

## Verification
Suppose the pending register or the mask held a wrong bit. That fault reaches the ports in one of two ways. It shows on `irq_out` in the very next cycle if the bit decides whether any enabled source is pending. Otherwise it shows in the read data of the next status or mask read, one cycle after that read is issued. A wrong acknowledge index, or a lost clear-over-set precedence, leaves a stale pending bit. That bit stays visible until something else clears it, so every later status read and every later unmask exposes it. Decode faults in the access path show as a missing or extra `acc_error` or a wrong `acc_rdata` in the response cycle itself. If the decode writes state on an errored access, the damage appears at the next read of the state it touched.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int unsigned SRC_W     = 8;
  localparam int unsigned OFS_W     = 8;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned ACK_IDX_W = 4;

  localparam logic [7:0] OFS_PRI_STAT = 8'h20;
  localparam logic [7:0] OFS_PRI_MASK = 8'h21;
  localparam logic [7:0] OFS_SEC_STAT = 8'hA0;
  localparam logic [7:0] OFS_SEC_MASK = 8'hA1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_PEND  = 2'd1,
    RD_PMASK = 2'd2,
    RD_SMASK = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    pmask_we;
    logic    smask_we;
    logic    ack_we;
    logic    err;
    rd_sel_e rd_sel;
  } acc_dec_t;

endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
  import lirq_pkg::*;
#(
  parameter int unsigned OW = OFS_W
) (
  input  logic          valid,
  input  logic          write,
  input  logic [1:0]    size,
  input  logic [OW-1:0] offset,
  output acc_dec_t      dec
);

  logic hit_stat, hit_pmask, hit_smask;

  always_comb begin
    hit_stat  = (offset == OW'(OFS_PRI_STAT));
    hit_pmask = (offset == OW'(OFS_PRI_MASK));
    hit_smask = (offset == OW'(OFS_SEC_MASK));
  end

  always_comb begin
    dec        = '0;
    dec.rd_sel = RD_ZERO;
    if (valid) begin
      case (size)
        SZ_BYTE: begin
          if (write) begin
            dec.pmask_we = hit_pmask;
            dec.smask_we = hit_smask;
            dec.ack_we   = hit_stat;
          end else if (hit_stat) begin
            dec.rd_sel = RD_PEND;
          end else if (hit_pmask) begin
            dec.rd_sel = RD_PMASK;
          end else if (hit_smask) begin
            dec.rd_sel = RD_SMASK;
          end
        end
        SZ_DBL: begin
          if (!write && hit_stat) dec.rd_sel = RD_PEND;
          else                    dec.err    = 1'b1;
        end
        default: dec.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/lirq_mask_reg.sv
module lirq_mask_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_en = we;
    mask_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= RST_VAL;
    else if (mask_en) mask_q <= mask_d;
  end

endmodule

// File: rtl/lirq_pending.sv
module lirq_pending #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  set_vec,
  input  logic [W-1:0]  clr_vec,
  input  logic          ack_we,
  input  logic [IW-1:0] ack_idx,
  output logic [W-1:0]  pend_q
);

  logic [W-1:0] ack_hit;
  logic [W-1:0] pend_d;
  logic         pend_en;

  for (genvar i = 0; i < W; i++) begin : g_ack
    assign ack_hit[i] = ack_we && (ack_idx == IW'(i));
  end

  always_comb begin
    pend_d  = ((pend_q | set_vec) & ~clr_vec) & ~ack_hit;
    pend_en = (|set_vec) | (|clr_vec) | ack_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

endmodule

// File: rtl/lirq_resp.sv
module lirq_resp
  import lirq_pkg::*;
#(
  parameter int unsigned W  = SRC_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          err,
  input  rd_sel_e       sel,
  input  logic [W-1:0]  pend,
  input  logic [W-1:0]  pmask,
  input  logic [W-1:0]  smask,
  output logic          ready_q,
  output logic          error_q,
  output logic [DW-1:0] rdata_q
);

  logic          ready_d, error_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    ready_d = valid;
    error_d = valid && err;
    rdata_d = '0;
    case (sel)
      RD_PEND:  rdata_d = DW'(pend);
      RD_PMASK: rdata_d = DW'(pmask);
      RD_SMASK: rdata_d = DW'(smask);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      error_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= ready_d;
      error_q <= error_d;
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/legacy_irq_ctrl.sv
module legacy_irq_ctrl
  import lirq_pkg::*;
#(
  parameter int unsigned W  = SRC_W,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = ACK_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_size,
  input  logic [OW-1:0] acc_offset,
  input  logic [W-1:0]  acc_wdata,
  output logic          acc_ready,
  output logic          acc_error,
  output logic [DW-1:0] acc_rdata,
  input  logic [W-1:0]  dev_set_vec,
  input  logic [W-1:0]  dev_clr_vec,
  output logic          irq_out
);

  localparam logic [W-1:0] PMASK_RST = {W{1'b1}};

  acc_dec_t     dec;
  logic [W-1:0] pend_q;
  logic [W-1:0] pmask_q;
  logic [W-1:0] smask_q;
  logic [W-1:0] pri_en;

  lirq_decode #(.OW(OW)) u_dec (
    .valid  (acc_valid),
    .write  (acc_write),
    .size   (acc_size),
    .offset (acc_offset),
    .dec    (dec)
  );

  lirq_mask_reg #(.W(W), .RST_VAL(PMASK_RST)) u_pmask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (dec.pmask_we),
    .wdata  (acc_wdata),
    .mask_q (pmask_q)
  );

  lirq_mask_reg #(.W(W), .RST_VAL('0)) u_smask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (dec.smask_we),
    .wdata  (acc_wdata),
    .mask_q (smask_q)
  );

  lirq_pending #(.W(W), .IW(IW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (dev_set_vec),
    .clr_vec (dev_clr_vec),
    .ack_we  (dec.ack_we),
    .ack_idx (acc_wdata[IW-1:0]),
    .pend_q  (pend_q)
  );

  lirq_resp #(.W(W), .DW(DW)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (acc_valid),
    .err     (dec.err),
    .sel     (dec.rd_sel),
    .pend    (pend_q),
    .pmask   (pmask_q),
    .smask   (smask_q),
    .ready_q (acc_ready),
    .error_q (acc_error),
    .rdata_q (acc_rdata)
  );

  always_comb begin
    pri_en  = ~pmask_q;
    irq_out = |(pend_q & pri_en);
  end

endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int unsigned W  = SRC_W,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned DW = DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [1:0]    acc_size,
  input logic [OW-1:0] acc_offset,
  input logic [W-1:0]  acc_wdata,
  input logic          acc_ready,
  input logic          acc_error,
  input logic [DW-1:0] acc_rdata,
  input logic [W-1:0]  dev_set_vec,
  input logic [W-1:0]  dev_clr_vec,
  input logic          irq_out,
  input logic [W-1:0]  pend,
  input logic [W-1:0]  en
);

  logic         ack_acc;
  logic         sec_rd;
  logic [W-1:0] post_only;

  always_comb begin
    ack_acc   = acc_valid && acc_write && (acc_size == SZ_BYTE) &&
                (acc_offset == OW'(OFS_PRI_STAT));
    sec_rd    = acc_valid && !acc_write && (acc_size == SZ_BYTE) &&
                (acc_offset == OW'(OFS_SEC_STAT));
    post_only = dev_set_vec & ~dev_clr_vec;
  end

  AST_READY_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> acc_ready); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_ready); // R3
  AST_ERROR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_error |-> acc_ready); // R10
  AST_ERROR_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_error |-> $stable(en)); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_clr_vec) |=> ((pend & $past(dev_clr_vec)) == '0)); // R5
  AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|post_only) && !ack_acc) |=> ((pend & $past(post_only)) == $past(post_only))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_acc && !acc_wdata[3]) |=> !pend[$past(acc_wdata[2:0])]); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_out); // R6
  AST_SEC_STUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rd |=> (acc_rdata == '0)); // R7

endmodule

bind legacy_irq_ctrl lirq_checker #(.W(W), .OW(OW), .DW(DW)) u_lirq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_size    (acc_size),
  .acc_offset  (acc_offset),
  .acc_wdata   (acc_wdata),
  .acc_ready   (acc_ready),
  .acc_error   (acc_error),
  .acc_rdata   (acc_rdata),
  .dev_set_vec (dev_set_vec),
  .dev_clr_vec (dev_clr_vec),
  .irq_out     (irq_out),
  .pend        (pend_q),
  .en          (pri_en)
);

// File: tb/test_legacy_irq_ctrl.sv
module test_legacy_irq_ctrl;

  logic        clk, rst_n;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_size;
  logic [7:0]  acc_offset, acc_wdata, dev_set_vec, dev_clr_vec;
  logic        acc_ready, acc_error, irq_out;
  logic [63:0] acc_rdata;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  bit    live   = 0;
  string tag    = "R1";

  int          m_pend, m_mask, m_smask, m_rdy, m_err;
  logic [63:0] m_rd;

  legacy_irq_ctrl i_legacy_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .acc_error(acc_error), .acc_rdata(acc_rdata),
    .dev_set_vec(dev_set_vec), .dev_clr_vec(dev_clr_vec), .irq_out(irq_out)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin : ref_model
    int rd_v, err_v, np;
    if (!rst_n) begin
      m_pend = 0; m_mask = 255; m_smask = 0;
      m_rdy = 0; m_err = 0; m_rd = '0; live = 1;
    end else begin
      rd_v = 0; err_v = 0;
      if (acc_valid) begin
        if (acc_size == 2'd0) begin
          if (!acc_write) begin
            if (acc_offset == 8'h20)      rd_v = m_pend;
            else if (acc_offset == 8'h21) rd_v = m_mask;
            else if (acc_offset == 8'hA1) rd_v = m_smask;
          end
        end else if (acc_size == 2'd3 && !acc_write && acc_offset == 8'h20) begin
          rd_v = m_pend;
        end else begin
          err_v = 1;
        end
      end
      np = (m_pend | int'(dev_set_vec)) & ~int'(dev_clr_vec);
      if (acc_valid && acc_size == 2'd0 && acc_write) begin
        if (acc_offset == 8'h21) m_mask  = acc_wdata;
        if (acc_offset == 8'hA1) m_smask = acc_wdata;
        if (acc_offset == 8'h20 && (acc_wdata % 16) < 8)
          np = np & ~(1 << (acc_wdata % 16));
      end
      m_pend = np & 255;
      m_rdy  = acc_valid ? 1 : 0;
      m_err  = err_v;
      m_rd   = 64'(rd_v);
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s): actual %h expected %h", what, tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R6 irq_out", 64'(irq_out), 64'((m_pend & ~m_mask & 255) != 0));
      chk("R3 acc_ready", 64'(acc_ready), 64'(m_rdy));
      chk("R10 acc_error", 64'(acc_error), 64'(m_err));
      chk("R3 acc_rdata", acc_rdata, m_rd);
    end
  end

  task automatic cyc(input bit v, input bit w, input logic [1:0] sz,
                     input logic [7:0] off, input logic [7:0] d,
                     input logic [7:0] s, input logic [7:0] c);
    @(posedge clk); #2;
    acc_valid = v; acc_write = w; acc_size = sz; acc_offset = off;
    acc_wdata = d; dev_set_vec = s; dev_clr_vec = c;
  endtask

  task automatic idle();
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (phase %s): actual running expected finished", tag);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_size = 0;
    acc_offset = 0; acc_wdata = 0; dev_set_vec = 0; dev_clr_vec = 0;
    tag = "R1";
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();

    tag = "R2";  // enable low nibble, read mask back
    cyc(1, 1, 2'd0, 8'h21, 8'hF0, 0, 0);
    cyc(1, 0, 2'd0, 8'h21, 8'h00, 0, 0);
    idle();

    tag = "R5";
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'h81, 8'h00);
    idle();

    tag = "R3";
    cyc(1, 0, 2'd0, 8'h20, 8'h00, 0, 0);
    idle();

    tag = "R4";
    cyc(1, 1, 2'd0, 8'h20, 8'h00, 0, 0);
    cyc(1, 1, 2'd0, 8'h20, 8'h0C, 0, 0);
    cyc(1, 0, 2'd0, 8'h20, 8'h00, 0, 0);
    cyc(1, 1, 2'd0, 8'h20, 8'h17, 0, 0);
    cyc(1, 0, 2'd0, 8'h20, 8'h00, 0, 0);
    idle();

    tag = "R6";
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'h10, 8'h00);
    cyc(1, 1, 2'd0, 8'h21, 8'hEF, 0, 0);
    cyc(1, 1, 2'd0, 8'h21, 8'hFF, 0, 0);
    cyc(1, 1, 2'd0, 8'h21, 8'h00, 0, 0);
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'h00, 8'h10);
    idle();

    tag = "R5";  // clear beats set, acknowledge beats set
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'h22, 8'h02);
    cyc(1, 1, 2'd0, 8'h20, 8'h00, 8'h01, 8'h00);
    cyc(1, 0, 2'd0, 8'h20, 8'h00, 0, 0);
    idle();

    tag = "R7";
    cyc(1, 1, 2'd0, 8'hA0, 8'h05, 0, 0);
    cyc(1, 0, 2'd0, 8'hA0, 8'h00, 0, 0);
    cyc(1, 0, 2'd0, 8'h20, 8'h00, 0, 0);
    idle();

    tag = "R8";
    cyc(1, 1, 2'd0, 8'h21, 8'hFF, 0, 0);
    cyc(1, 1, 2'd0, 8'hA1, 8'h00, 8'h08, 0);
    cyc(1, 0, 2'd0, 8'hA1, 8'h00, 0, 0);
    cyc(1, 1, 2'd0, 8'hA1, 8'h5A, 0, 0);
    cyc(1, 0, 2'd0, 8'hA1, 8'h00, 0, 0);
    idle();

    tag = "R9";
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'hC3, 8'h00);
    cyc(1, 0, 2'd3, 8'h20, 8'h00, 0, 0);
    idle();

    tag = "R10";
    cyc(1, 0, 2'd1, 8'h20, 8'h00, 0, 0);
    cyc(1, 1, 2'd2, 8'h21, 8'h00, 0, 0);
    cyc(1, 0, 2'd3, 8'h21, 8'h00, 0, 0);
    cyc(1, 1, 2'd3, 8'h20, 8'h00, 0, 0);
    cyc(1, 1, 2'd1, 8'h20, 8'h07, 0, 0);
    cyc(1, 1, 2'd2, 8'hA1, 8'hFF, 0, 0);
    cyc(1, 0, 2'd0, 8'h21, 8'h00, 0, 0);
    cyc(1, 0, 2'd0, 8'h20, 8'h00, 0, 0);
    cyc(1, 0, 2'd0, 8'hA1, 8'h00, 0, 0);
    idle();

    tag = "R11";
    cyc(1, 1, 2'd0, 8'h30, 8'h55, 0, 0);
    cyc(1, 0, 2'd0, 8'h30, 8'h00, 0, 0);
    cyc(1, 0, 2'd0, 8'h21, 8'h00, 0, 0);
    idle();

    tag = "R6";  // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] offs [5];
      int r;
      offs[0] = 8'h20; offs[1] = 8'h21; offs[2] = 8'hA0;
      offs[3] = 8'hA1; offs[4] = 8'h30;
      r = int'($urandom_range(0, 9));
      cyc(($urandom_range(0, 2) != 0), $urandom_range(0, 1) == 1,
          (r < 7) ? 2'd0 : 2'($urandom_range(1, 3)),
          offs[$urandom_range(0, 4)], 8'($urandom),
          ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00,
          ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
    end
    idle();
    idle();
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule